// File: doc/BRIEF.md
# NAND Flash Operation Trigger Engine

This block sits between a host register port and the pins of a NAND flash device. The host loads a command byte, an address byte, a buffer number and a configuration word. It then starts a single flash operation by writing a one-hot code into the operation control word. The engine performs that operation on the flash pins and moves any data through an external byte-wide buffer RAM. The six operations are:

- a command latch cycle
- an address latch cycle
- a page program transfer (buffer to flash)
- a page read transfer (flash to buffer)
- a device-ID read
- a status read

When the operation ends, a sticky completion flag is set in bit 15 of the control word. An interrupt line follows that flag unless the mask bit of the configuration word is set. The host clears the flag by writing the control word with bit 15 at 0. The buffer RAM is split into four regions of 528 bytes each: 512 main bytes followed by 16 spare bytes. The buffer-select register picks the region.

Top module: `nand_op_engine`

## Requirements
- R1: After reset all registers read 0, `irq` is low, `fl_we_n` and `fl_re_n` are high, and `fl_cle` and `fl_ale` are low.
- R2: Register address 0 is the control word. Writing it with bit 0, 1, 2, 3, 4 or 5 set starts a command, address, page-program, page-read, read-ID or read-status operation respectively. While the operation runs, its bit reads back as 1. When the operation ends, bits 5..0 read back as 0.
- R3: A command operation gives one `fl_we_n` low cycle with `fl_cle` high and drives the byte held at register address 3. An address operation does the same with `fl_ale` high and drives the byte held at register address 4. `fl_cle` and `fl_ale` are never high together.
- R4: Bit 15 of the control word is set when an operation ends. It stays set until a control-word write has bit 15 at 0. A write with bit 15 at 1 leaves it unchanged.
- R5: `irq` is high exactly when the completion flag is set and bit 4 of the configuration word (register address 1) is 0.
- R6: Page-program, page-read and read-ID operations send no `fl_we_n` or `fl_re_n` pulse until `fl_rdy` is high.
- R7: A page read makes 528 `fl_re_n` pulses. It stores byte k at `buf_addr` = {buffer select (register address 2, bits 1..0), k as 10 bits}, for k from 0 to 527.
- R8: A page program makes 528 `fl_we_n` pulses with `fl_cle` and `fl_ale` low. Pulse k drives the buffer byte at offset k of the selected region.
- R9: With configuration bit 2 set, page reads and page programs move only offsets 512 to 527 (16 pulses).
- R10: A read-ID operation makes 6 `fl_re_n` pulses and stores them at offsets 0 to 5 of the selected region.
- R11: A read-status operation issues a command cycle carrying 0x70. It then makes one `fl_re_n` pulse, without waiting for `fl_rdy`, and stores the byte at offset 0 of the selected region.
- R12: Every register write made while an operation runs is ignored. If a control write has several of bits 5..0 set, only the lowest one starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| irq | output | 1 | Masked completion interrupt |
| fl_cle | output | 1 | Flash command latch enable |
| fl_ale | output | 1 | Flash address latch enable |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_re_n | output | 1 | Flash read enable, active low |
| fl_oe | output | 1 | Output enable for the flash data bus |
| fl_dout | output | 8 | Byte driven to flash |
| fl_din | input | 8 | Byte from flash |
| fl_rdy | input | 1 | Flash ready (high) / busy (low) |
| buf_addr | output | 12 | Buffer RAM byte address {region, offset} |
| buf_we | output | 1 | Buffer RAM write enable |
| buf_wdata | output | 8 | Buffer RAM write data |
| buf_rdata | input | 8 | Buffer RAM read data, valid in the same cycle as buf_addr |

## Verification
The bench starts an operation while `fl_rdy` is low, then writes the control, command and configuration registers during the wait. A design that polled too early would pulse `fl_re_n` during the wait. A design that accepted writes while busy would emit an extra command cycle or load a new mask.

Several boundaries are driven directly:
- The spare-only mode must start at offset 512. A wrong start would overwrite main bytes or drop spare bytes.
- Read-status must complete while the device reports busy. A design that waited for ready would hang.
- A control write with both bit 0 and bit 1 set must give only the command cycle.
- A write of 1 to bit 15 must not clear the completion flag.

// File: rtl/nand_op_engine.sv
module nand_op_engine #(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int NUM_BUFS    = 4,
  parameter int ID_BYTES    = 6,
  parameter logic [7:0] STATUS_OPCODE = 8'h70,
  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES,
  localparam int IDX_W      = $clog2(PAGE_BYTES),
  localparam int SEL_W      = $clog2(NUM_BUFS),
  localparam int BA_W       = SEL_W + IDX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [15:0]     wr_data,
  input  logic [2:0]      rd_addr,
  output logic [15:0]     rd_data,
  output logic            irq,
  output logic            fl_cle,
  output logic            fl_ale,
  output logic            fl_we_n,
  output logic            fl_re_n,
  output logic            fl_oe,
  output logic [7:0]      fl_dout,
  input  logic [7:0]      fl_din,
  input  logic            fl_rdy,
  output logic [BA_W-1:0] buf_addr,
  output logic            buf_we,
  output logic [7:0]      buf_wdata,
  input  logic [7:0]      buf_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_LAT_LO, S_LAT_HI, S_WAIT, S_XF_LO, S_XF_HI} st_t;

  st_t              st;
  logic [5:0]       op_q;
  logic             done_q;
  logic [8:0]       cfg_q;
  logic [SEL_W-1:0] sel_q;
  logic [7:0]       cmd_q, adr_q, lat_byte;
  logic             lat_cle, lat_ale;
  logic [IDX_W-1:0] idx_q, last_q;
  logic             busy, in_lat, prog;
  logic [5:0]       pick;

  assign busy   = (st != S_IDLE);
  assign in_lat = (st == S_LAT_LO) || (st == S_LAT_HI);
  assign prog   = op_q[2];
  assign pick   = wr_data[5:0] & (~wr_data[5:0] + 6'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= '0; done_q <= 1'b0; cfg_q <= '0; sel_q <= '0;
      cmd_q <= '0; adr_q <= '0; lat_byte <= '0; lat_cle <= 1'b0; lat_ale <= 1'b0;
      idx_q <= '0; last_q <= '0;
    end else if (!busy) begin
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin
            done_q <= done_q & wr_data[15];
            op_q   <= pick;
            lat_cle <= pick[0] | pick[5];
            lat_ale <= pick[1];
            lat_byte <= pick[1] ? adr_q : (pick[5] ? STATUS_OPCODE : cmd_q);
            if (pick[2] || pick[3]) begin
              idx_q  <= cfg_q[2] ? IDX_W'(MAIN_BYTES) : '0;
              last_q <= IDX_W'(PAGE_BYTES - 1);
            end else begin
              idx_q  <= '0;
              last_q <= pick[4] ? IDX_W'(ID_BYTES - 1) : '0;
            end
            if (pick[0] || pick[1] || pick[5]) st <= S_LAT_LO;
            else if (pick != 6'd0)             st <= S_WAIT;
          end
          3'd1: cfg_q <= wr_data[8:0];
          3'd2: sel_q <= wr_data[SEL_W-1:0];
          3'd3: cmd_q <= wr_data[7:0];
          3'd4: adr_q <= wr_data[7:0];
          default: ;
        endcase
      end
    end else begin
      case (st)
        S_LAT_LO: st <= S_LAT_HI;
        S_LAT_HI:
          if (op_q[5]) st <= S_XF_LO;
          else begin st <= S_IDLE; done_q <= 1'b1; op_q <= '0; end
        S_WAIT:  if (fl_rdy) st <= S_XF_LO;
        S_XF_LO: st <= S_XF_HI;
        S_XF_HI:
          if (idx_q == last_q) begin st <= S_IDLE; done_q <= 1'b1; op_q <= '0; end
          else begin idx_q <= idx_q + 1'b1; st <= S_XF_LO; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign fl_cle    = in_lat & lat_cle;
  assign fl_ale    = in_lat & lat_ale;
  assign fl_we_n   = !((st == S_LAT_LO) || ((st == S_XF_LO) && prog));
  assign fl_re_n   = !((st == S_XF_LO) && !prog);
  assign fl_oe     = in_lat || (((st == S_XF_LO) || (st == S_XF_HI)) && prog);
  assign fl_dout   = in_lat ? lat_byte : buf_rdata;
  assign buf_addr  = {sel_q, idx_q};
  assign buf_we    = (st == S_XF_LO) && !prog;
  assign buf_wdata = fl_din;
  assign irq       = done_q & ~cfg_q[4];

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {done_q, 9'd0, op_q};
      3'd1:    rd_data = {7'd0, cfg_q};
      3'd2:    rd_data = 16'(sel_q);
      3'd3:    rd_data = {8'd0, cmd_q};
      3'd4:    rd_data = {8'd0, adr_q};
      default: rd_data = 16'd0;
    endcase
  end
endmodule

module nand_op_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [15:0] wr_data,
  input logic        irq,
  input logic        fl_cle,
  input logic        fl_ale,
  input logic        fl_we_n,
  input logic        fl_re_n,
  input logic        done_q,
  input logic        busy,
  input logic [8:0]  cfg_q
);
  assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[4] |-> !irq);
  assert_latch_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_cle && fl_ale));
  assert_strobe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_re_n));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fl_we_n && fl_re_n && !fl_cle && !fl_ale));
  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(wr_en && wr_addr == 3'd0 && !wr_data[15])) |=> done_q);
  assert_busy_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_addr == 3'd1) |=> $stable(cfg_q));
endmodule

bind nand_op_engine nand_op_checker u_chk (.*);

// File: tb/sim_nand_op_engine.sv
`timescale 1ns/1ps
module sim_nand_op_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic irq, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_oe, fl_rdy = 1'b1;
  logic [7:0] fl_dout, fl_din, buf_wdata, buf_rdata;
  logic [11:0] buf_addr;
  logic buf_we;

  int tests = 0, fails = 0;
  logic [7:0] mem [4096];
  int re_cnt = 0, we_cnt = 0, lat_cnt = 0, din_cnt = 0, din_err = 0, din_base = 0;
  logic re_low = 1'b0;
  logic [7:0] lat_byte_log; logic lat_cle_log, lat_ale_log;

  nand_op_engine u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fl_din    = 8'((re_cnt * 7) + 1);
  assign buf_rdata = mem[buf_addr];

  always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_wdata;

  always @(negedge clk) begin
    if (!fl_re_n) re_low <= 1'b1;
    else if (re_low) begin re_low <= 1'b0; re_cnt <= re_cnt + 1; end
    if (!fl_we_n) begin
      we_cnt <= we_cnt + 1;
      if (fl_cle || fl_ale) begin
        lat_cnt <= lat_cnt + 1; lat_byte_log <= fl_dout;
        lat_cle_log <= fl_cle; lat_ale_log <= fl_ale;
      end else begin
        if (fl_dout !== 8'((din_cnt - din_base) * 3 + 5)) din_err <= din_err + 1;
        din_cnt <= din_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wait_done(input string req);
    logic [15:0] v;
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk); rd(3'd0, v);
      if (v[15]) return;
    end
    check(req, 0, 1);
  endtask

  task automatic clear_done();
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 5; a++) begin rd(3'(a), v); check("R1 reg", v, 0); end
    check("R1 irq", irq, 0);
    check("R1 strobes", {fl_we_n, fl_re_n, fl_cle, fl_ale}, 4'b1100);
  endtask

  task automatic t_cmd_addr();
    int l0;
    logic [15:0] v;
    wr(3'd3, 16'h005A); wr(3'd4, 16'h00C3);
    l0 = lat_cnt;
    wr(3'd0, 16'h0001); wait_done("R3 cmd");
    check("R3 cmd count", lat_cnt - l0, 1);
    check("R3 cmd byte", {lat_cle_log, lat_ale_log, lat_byte_log}, {2'b10, 8'h5A});
    rd(3'd0, v); check("R4 flag set", v, 16'h8000);
    check("R5 irq", irq, 1);
    wr(3'd0, 16'h8000); rd(3'd0, v); check("R4 write1 keeps", v[15], 1);
    clear_done(); rd(3'd0, v); check("R4 cleared", v[15], 0);
    check("R5 irq low", irq, 0);
    wr(3'd0, 16'h0002); wait_done("R3 addr");
    check("R3 addr byte", {lat_cle_log, lat_ale_log, lat_byte_log}, {2'b01, 8'hC3});
    clear_done();
  endtask

  task automatic t_priority();
    int l0;
    l0 = lat_cnt;
    wr(3'd0, 16'h0003); wait_done("R12 prio");
    check("R12 prio count", lat_cnt - l0, 1);
    check("R12 prio cle", {lat_cle_log, lat_ale_log}, 2'b10);
    clear_done();
  endtask

  task automatic t_read_busy();
    int r0, l0, errs;
    logic [15:0] v;
    wr(3'd2, 16'h0002);
    fl_rdy = 1'b0; r0 = re_cnt; l0 = lat_cnt;
    wr(3'd0, 16'h0008);
    rd(3'd0, v); check("R2 busy bit", v, 16'h0008);
    wr(3'd0, 16'h0001); wr(3'd1, 16'h0010); wr(3'd3, 16'h00EE);
    repeat (4) @(negedge clk);
    check("R6 no pulse while busy", re_cnt - r0, 0);
    fl_rdy = 1'b1;
    wait_done("R7 read");
    check("R7 pulses", re_cnt - r0, 528);
    check("R12 no extra cmd", lat_cnt - l0, 0);
    rd(3'd1, v); check("R12 cfg kept", v, 0);
    rd(3'd3, v); check("R12 cmd kept", v, 16'h005A);
    rd(3'd0, v); check("R2 op bits clear", v, 16'h8000);
    errs = 0;
    for (int k = 0; k < 528; k++)
      if (mem[{2'd2, 10'(k)}] !== 8'((r0 + k) * 7 + 1)) errs++;
    check("R7 data", errs, 0);
    clear_done();
  endtask

  task automatic t_program();
    int w0;
    for (int k = 0; k < 528; k++) mem[{2'd1, 10'(k)}] = 8'(k * 3 + 5);
    wr(3'd2, 16'h0001);
    din_base = din_cnt; w0 = din_cnt;
    @(negedge clk); din_err = 0;
    wr(3'd0, 16'h0004); wait_done("R8 prog");
    check("R8 pulses", din_cnt - w0, 528);
    check("R8 data", din_err, 0);
    clear_done();
  endtask

  task automatic t_spare();
    int r0, errs;
    for (int k = 0; k < 528; k++) mem[{2'd3, 10'(k)}] = 8'hA5;
    wr(3'd1, 16'h0004); wr(3'd2, 16'h0003);
    r0 = re_cnt;
    wr(3'd0, 16'h0008); wait_done("R9 spare");
    check("R9 pulses", re_cnt - r0, 16);
    errs = 0;
    for (int k = 0; k < 512; k++) if (mem[{2'd3, 10'(k)}] !== 8'hA5) errs++;
    for (int k = 0; k < 16; k++)
      if (mem[{2'd3, 10'(512 + k)}] !== 8'((r0 + k) * 7 + 1)) errs++;
    check("R9 placement", errs, 0);
    clear_done(); wr(3'd1, 16'h0000);
  endtask

  task automatic t_id();
    int r0, errs;
    wr(3'd2, 16'h0000);
    mem[{2'd0, 10'd6}] = 8'h3C;
    r0 = re_cnt;
    wr(3'd0, 16'h0010); wait_done("R10 id");
    check("R10 pulses", re_cnt - r0, 6);
    errs = 0;
    for (int k = 0; k < 6; k++) if (mem[{2'd0, 10'(k)}] !== 8'((r0 + k) * 7 + 1)) errs++;
    if (mem[{2'd0, 10'd6}] !== 8'h3C) errs++;
    check("R10 data", errs, 0);
    clear_done();
  endtask

  task automatic t_status();
    int r0;
    wr(3'd2, 16'h0001);
    fl_rdy = 1'b0; r0 = re_cnt;
    wr(3'd0, 16'h0020); wait_done("R11 status");
    check("R11 cmd", {lat_cle_log, lat_byte_log}, {1'b1, 8'h70});
    check("R11 pulses", re_cnt - r0, 1);
    check("R11 byte", mem[{2'd1, 10'd0}], 8'(r0 * 7 + 1));
    fl_rdy = 1'b1;
    clear_done();
  endtask

  task automatic t_mask();
    wr(3'd1, 16'h0010);
    wr(3'd0, 16'h0001); wait_done("R5 mask");
    check("R5 masked irq", irq, 0);
    wr(3'd1, 16'h0000); #1;
    check("R5 unmasked irq", irq, 1);
    clear_done();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_cmd_addr();
    t_priority();
    t_read_busy();
    t_program();
    t_spare();
    t_id();
    t_status();
    t_mask();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule